// File: doc/BRIEF.md
# Boost Converter Load-Detect and Overcurrent Supervisor

This block watches a boost converter through three digital status inputs: a comparator that reports the sense-resistor voltage above the load-detect level, a comparator that reports it above the overcurrent level, and a flag that tells whether the converter is in pulse-skip operation. A slow timing strobe (one pulse per millisecond at the nominal internal clock) measures how long each condition lasts. Short glitches are ignored. Conditions that last are turned into a load-present status, a sticky overcurrent flag and a request to disconnect the load.

Load presence is hysteretic. It is declared when the sense level stays high, or when the converter stays out of pulse-skip, for longer than the detect window. It is withdrawn only when the level stays low and the converter stays in pulse-skip, together, for the same window. An overcurrent that lasts longer than the overcurrent window sets a sticky flag. Only a 0-then-1 sequence on the protection enable removes that flag. When the disconnect option is on, the flag also drives the disconnect output. One-cycle event pulses go to an interrupt controller on the rising edge of either status. When the internal clock is halved, a rate input makes every window twice as long.

Top module: `boost_load_guard`

## Requirements
- R1: After reset all outputs (`load_det`, `oc_flag`, `load_off`, `det_evt`, `oc_evt`) are 0.
- R2: With `prot_en`=1, `load_det` goes to 1 one cycle after the strobe on which the set condition (`det_hi`=1 or `pskip`=0) has been held continuously for DET_MS+1 counted strobes.
- R3: `load_det` returns to 0 only after the clear condition (`det_hi`=0 and `pskip`=1) has been held continuously for DET_MS+1 counted strobes. The same timing as R2 applies.
- R4: A persistence count restarts from zero on any cycle in which its condition is absent. Conditions interrupted before the limit never change a status.
- R5: `oc_flag` goes to 1 one cycle after `oc_hi` has been held continuously for OC_MS+1 counted strobes.
- R6: Once set, `oc_flag` stays 1 whatever `oc_hi` does. It clears in the cycle after `prot_en` is sampled 0, and stays 0 after `prot_en` returns to 1 until a new R5 qualification.
- R7: `load_off` equals `oc_flag` AND `disc_en`. It rises in the same cycle as `oc_flag` and follows a change of `disc_en` one cycle later.
- R8: `det_evt` and `oc_evt` are single-cycle pulses, high exactly in the cycle when `load_det` or `oc_flag` rises. Falling edges make no pulse.
- R9: While `prot_en` is sampled 0, `load_det`, `oc_flag` and `load_off` are 0 in the following cycle, all counts are cleared, and no event fires.
- R10: With `half_rate`=1, only every second strobe is counted. The first strobe after reset or after enable is skipped, so every window doubles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_en | input | 1 | Protection and detection enable |
| disc_en | input | 1 | Allow disconnect on sticky overcurrent |
| half_rate | input | 1 | Internal clock halved: count every second strobe |
| tick | input | 1 | One-cycle timing strobe (1 ms nominal) |
| det_hi | input | 1 | Sense voltage above load-detect level |
| oc_hi | input | 1 | Sense voltage above overcurrent level (already hysteresis-filtered) |
| pskip | input | 1 | Converter is in pulse-skip operation |
| load_det | output | 1 | Load-present status |
| oc_flag | output | 1 | Sticky overcurrent flag |
| load_off | output | 1 | Load disconnect request |
| det_evt | output | 1 | Rising-edge event of `load_det` |
| oc_evt | output | 1 | Rising-edge event of `oc_flag` |

## Verification
The assertions assume the strobe is a clean single-cycle pulse and that every input is synchronous to `clk`. The comparator inputs are assumed glitch-free within a cycle, so the overcurrent input needs no debounce beyond its persistence window. The stimulus drives all inputs on the falling clock edge. It spaces strobes several cycles apart, and it makes condition gaps shorter than one strobe period to exercise restarts. It toggles `prot_en` and `disc_en` only between whole cycles.

// File: rtl/blg_pkg.sv
package blg_pkg;
  // index of each persistence channel
  localparam int CH_SET = 0;
  localparam int CH_CLR = 1;
  localparam int CH_OC  = 2;
  localparam int N_CH   = 3;

  function automatic int cnt_width(input int limit);
    return $clog2(limit + 2);
  endfunction
endpackage

// File: rtl/blg_tick_scale.sv
module blg_tick_scale (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic half_rate,
  input  logic tick,
  output logic eff_tick
);
  logic phase;

  always_ff @(posedge clk) begin
    if (rst || clr) phase <= 1'b0;
    else if (tick)  phase <= ~phase;
  end

  assign eff_tick = tick & (~half_rate | phase);
endmodule

// File: rtl/blg_persist.sv
module blg_persist #(
  parameter int LIMIT = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic cond,
  input  logic step,
  output logic done
);
  localparam int W = blg_pkg::cnt_width(LIMIT);
  localparam logic [W-1:0] FULL = W'(LIMIT + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr || !cond)     cnt <= '0;
    else if (step && cnt != FULL) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == FULL);
endmodule

// File: rtl/boost_load_guard.sv
module boost_load_guard #(
  parameter int DET_MS = 1,
  parameter int OC_MS  = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic prot_en,
  input  logic disc_en,
  input  logic half_rate,
  input  logic tick,
  input  logic det_hi,
  input  logic oc_hi,
  input  logic pskip,
  output logic load_det,
  output logic oc_flag,
  output logic load_off,
  output logic det_evt,
  output logic oc_evt
);
  import blg_pkg::*;

  logic             eff_tick;
  logic [N_CH-1:0]  cond;
  logic [N_CH-1:0]  done;
  logic             oc_next;

  blg_tick_scale u_scale (
    .clk(clk), .rst(rst), .clr(~prot_en),
    .half_rate(half_rate), .tick(tick), .eff_tick(eff_tick)
  );

  assign cond[CH_SET] = det_hi | ~pskip;
  assign cond[CH_CLR] = ~det_hi & pskip;
  assign cond[CH_OC]  = oc_hi;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    localparam int LIM = (i == CH_OC) ? OC_MS : DET_MS;
    blg_persist #(.LIMIT(LIM)) u_tmr (
      .clk(clk), .rst(rst), .clr(~prot_en),
      .cond(cond[i]), .step(eff_tick), .done(done[i])
    );
  end

  assign oc_next = prot_en & (oc_flag | done[CH_OC]);

  always_ff @(posedge clk) begin
    if (rst) begin
      load_det <= 1'b0;
      det_evt  <= 1'b0;
      oc_flag  <= 1'b0;
      oc_evt   <= 1'b0;
      load_off <= 1'b0;
    end else begin
      det_evt <= 1'b0;
      if (!prot_en) begin
        load_det <= 1'b0;
      end else if (!load_det && done[CH_SET]) begin
        load_det <= 1'b1;
        det_evt  <= 1'b1;
      end else if (load_det && done[CH_CLR]) begin
        load_det <= 1'b0;
      end
      oc_flag  <= oc_next;
      oc_evt   <= oc_next & ~oc_flag;
      load_off <= oc_next & disc_en;
    end
  end
endmodule

// File: rtl/blg_checker.sv
module blg_checker (
  input logic clk,
  input logic rst,
  input logic prot_en,
  input logic disc_en,
  input logic load_det,
  input logic oc_flag,
  input logic load_off,
  input logic det_evt,
  input logic oc_evt
);
  // R7: disconnect only with sticky flag and permission
  assert_off_needs_flag_R7: assert property (@(posedge clk) disable iff (rst)
    load_off |-> (oc_flag && $past(disc_en)));

  // R6: the flag holds while enabled
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (oc_flag && prot_en) |=> oc_flag);

  // R9: disable clears everything
  assert_disable_clears_R9: assert property (@(posedge clk) disable iff (rst)
    !prot_en |=> (!load_det && !oc_flag && !load_off && !det_evt && !oc_evt));

  // R8: event pulses match rising edges
  assert_det_evt_rise_R8: assert property (@(posedge clk) disable iff (rst)
    det_evt |-> $rose(load_det));
  assert_det_rise_evt_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(load_det) |-> det_evt);
  assert_oc_evt_rise_R8: assert property (@(posedge clk) disable iff (rst)
    oc_evt == $rose(oc_flag));
endmodule

bind boost_load_guard blg_checker u_blg_checker (
  .clk(clk), .rst(rst), .prot_en(prot_en), .disc_en(disc_en),
  .load_det(load_det), .oc_flag(oc_flag), .load_off(load_off),
  .det_evt(det_evt), .oc_evt(oc_evt)
);

// File: tb/test_boost_load_guard.sv
module test_boost_load_guard;
  localparam int CLK_PERIOD = 10;
  localparam int TP         = 4;   // cycles between strobes
  localparam int DET_MS     = 1;
  localparam int OC_MS      = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prot_en = 1'b0, disc_en = 1'b0, half_rate = 1'b0, tick = 1'b0;
  logic det_hi = 1'b0, oc_hi = 1'b0, pskip = 1'b1;
  logic load_det, oc_flag, load_off, det_evt, oc_evt;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boost_load_guard #(.DET_MS(DET_MS), .OC_MS(OC_MS)) i_boost_load_guard (
    .clk(clk), .rst(rst), .prot_en(prot_en), .disc_en(disc_en),
    .half_rate(half_rate), .tick(tick), .det_hi(det_hi), .oc_hi(oc_hi),
    .pskip(pskip), .load_det(load_det), .oc_flag(oc_flag),
    .load_off(load_off), .det_evt(det_evt), .oc_evt(oc_evt)
  );

  // behavioural reference model
  int  m_set = 0, m_clr = 0, m_oc = 0;
  bit  m_ph = 0;
  bit  m_det = 0, m_devt = 0, m_flag = 0, m_oevt = 0, m_off = 0;

  always @(posedge clk) begin
    bit et, d_set, d_clr, d_oc, nxt;
    if (rst) begin
      m_set = 0; m_clr = 0; m_oc = 0; m_ph = 0;
      m_det = 0; m_devt = 0; m_flag = 0; m_oevt = 0; m_off = 0;
    end else begin
      et    = tick && (!half_rate || m_ph);
      d_set = (m_set > DET_MS);
      d_clr = (m_clr > DET_MS);
      d_oc  = (m_oc  > OC_MS);
      if (!prot_en) m_ph = 0; else if (tick) m_ph = !m_ph;
      if (!prot_en || !(det_hi || !pskip)) m_set = 0;
      else if (et && m_set <= DET_MS) m_set++;
      if (!prot_en || !(!det_hi && pskip)) m_clr = 0;
      else if (et && m_clr <= DET_MS) m_clr++;
      if (!prot_en || !oc_hi) m_oc = 0;
      else if (et && m_oc <= OC_MS) m_oc++;
      m_devt = 0;
      if (!prot_en) m_det = 0;
      else if (!m_det && d_set) begin m_det = 1; m_devt = 1; end
      else if (m_det && d_clr) m_det = 0;
      nxt    = prot_en && (m_flag || d_oc);
      m_oevt = nxt && !m_flag;
      m_flag = nxt;
      m_off  = nxt && disc_en;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  // one cycle: compare at falling edge, then drive next strobe
  task automatic step();
    @(negedge clk);
    cyc++;
    if (!rst) begin
      chk("R2 R3 R4 R10 load_det", load_det, m_det);
      chk("R5 R6 oc_flag", oc_flag, m_flag);
      chk("R7 load_off", load_off, m_off);
      chk("R8 det_evt", det_evt, m_devt);
      chk("R8 oc_evt", oc_evt, m_oevt);
    end
    tick = (cyc % TP == 0);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    run(3);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 load_det", load_det, 0);
    chk("R1 oc_flag", oc_flag, 0);
    chk("R1 load_off", load_off, 0);
    chk("R1 evts", det_evt | oc_evt, 0);

    // idle, enabled
    prot_en = 1'b1;
    run(20);
    chk("R2 idle load_det", load_det, 0);

    // set by sense level
    det_hi = 1'b1;
    run(16);
    chk("R2 set by det_hi", load_det, 1);

    // clear path
    det_hi = 1'b0;
    run(16);
    chk("R3 cleared", load_det, 0);

    // short pulse-skip gaps never qualify
    for (int k = 0; k < 6; k++) begin
      pskip = 1'b0; run(3);
      pskip = 1'b1; run(3);
    end
    chk("R4 gaps ignored", load_det, 0);

    // set by leaving pulse-skip, clear blocked while det_hi
    pskip = 1'b0;
    run(16);
    chk("R2 set by pskip", load_det, 1);
    pskip = 1'b1; det_hi = 1'b1;
    run(16);
    chk("R3 held while det_hi", load_det, 1);
    det_hi = 1'b0;
    run(16);

    // overcurrent with disconnect
    disc_en = 1'b1; oc_hi = 1'b1;
    run(40);
    chk("R5 flag set", oc_flag, 1);
    chk("R7 off set", load_off, 1);
    oc_hi = 1'b0;
    run(20);
    chk("R6 sticky", oc_flag, 1);
    disc_en = 1'b0;
    run(2);
    chk("R7 off follows disc_en", load_off, 0);

    // disable clears, re-enable keeps cleared
    prot_en = 1'b0;
    run(3);
    chk("R9 flag cleared", oc_flag, 0);
    chk("R9 det cleared", load_det, 0);
    prot_en = 1'b1;
    run(10);
    chk("R6 stays clear", oc_flag, 0);

    // short overcurrent bursts
    for (int k = 0; k < 5; k++) begin
      oc_hi = 1'b1; run(15);
      oc_hi = 1'b0; run(2);
    end
    chk("R4 oc bursts ignored", oc_flag, 0);

    // half rate
    half_rate = 1'b1;
    prot_en = 1'b0; run(2); prot_en = 1'b1;
    det_hi = 1'b1;
    run(40);
    chk("R10 half-rate set", load_det, 1);
    oc_hi = 1'b1; disc_en = 1'b1;
    run(60);
    chk("R10 half-rate oc", oc_flag, 1);

    // disable while conditions present
    prot_en = 1'b0;
    run(12);
    chk("R9 held off", load_det | oc_flag | load_off, 0);
    prot_en = 1'b1; half_rate = 1'b0;
    run(40);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule